// File: doc/BRIEF.md
# Short-Vector Register Index Sequencer

This block turns one short-vector floating-point instruction into a run of per-element register operations. An issue strobe carries three base register indices: a destination, a first source and a second source. The block then emits one element operation per cycle. Each operation carries the three register indices for that element, and a flag marks the final element. The register file and the arithmetic units sit outside the block. The block supplies only the index sequence and the element count.

The 32 registers form four banks of eight. Every index steps by a programmable stride and wraps inside the bank where it started. Bank 0 has a special meaning. A second source in bank 0 acts as one scalar that every element reuses. A destination in bank 0 turns the whole instruction into a single scalar operation.

A 32-bit control word sets the element count and the stride. It is reached through a read port and a write port. Both ports have fixed latencies. Bits that have no function are stored and read back unchanged, so software can use a read-modify-write to change only the length.

Top module: `svec_sequencer`

## Requirements
- R1: After reset, `busy` and `elemValid` are low and the control word reads back as zero. This gives length 1 and stride 1.
- R2: An accepted instruction with a destination outside bank 0 produces exactly L element operations. They come on consecutive cycles, starting in the cycle after acceptance. L is control bits 18:16 plus one. `busy` equals `elemValid` throughout, and `elemLast` is high only on the final element.
- R3: Bits 4:3 of an index give its bank and bits 2:0 give its offset. For element k, the destination and first source offsets are (base offset + k·stride) mod 8. The bank stays fixed.
- R4: When the second source lies in bank 0 (bits 4:3 = 0), every element carries that same index. Otherwise it advances as in R3.
- R5: When the destination lies in bank 0, exactly one element is produced, whatever the length field says.
- R6: The stride is 2 when control bits 21:20 are both 1. Every other code gives stride 1.
- R7: While `busy` is high, `issueValid` is ignored. The running sequence continues unchanged.
- R8: A write sampled on a clock edge changes the control word on the fourth edge, counting that one. A read or an instruction sampled on or before that fourth edge still sees the old word.
- R9: A read sampled on a clock edge raises `cfgRdValid` after the next edge. It returns all 32 bits exactly as last written, so a read-modify-write of the length bits leaves the other bits intact.
- R10: An instruction takes its length and stride at the edge that accepts it. Later writes do not alter a sequence already under way.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rstN | input | 1 | Active-low synchronous reset |
| issueValid | input | 1 | Instruction issue strobe |
| issueDst | input | 5 | Base destination register index |
| issueSrcA | input | 5 | Base first source register index |
| issueSrcB | input | 5 | Base second source register index |
| cfgWrEn | input | 1 | Control word write request |
| cfgWrData | input | 32 | Control word write value |
| cfgRdEn | input | 1 | Control word read request |
| cfgRdValid | output | 1 | Read data valid |
| cfgRdData | output | 32 | Read data |
| elemValid | output | 1 | Element operation valid |
| elemDst | output | 5 | Element destination index |
| elemSrcA | output | 5 | Element first source index |
| elemSrcB | output | 5 | Element second source index |
| elemLast | output | 1 | Final element of the instruction |
| busy | output | 1 | A sequence is in progress |

## Verification
The assertions check four things on every cycle. First, an index never leaves its bank, and it moves by one or two between elements. Second, a scalar second source stays fixed. Third, the count drops by one per element, and a bank-0 destination yields a single element. Fourth, the control word changes only a write latency after a write, and read data matches the word as it stood a read latency earlier. Only the bench scenarios can show the exact element count for each length code and the wrap point of each stride. They also show that issue strobes during `busy` are dropped, that a write landing mid-sequence leaves the running instruction alone, and that a read-modify-write keeps the unused bits.

// File: rtl/svec_pkg.sv
package svec_pkg;
  localparam int IDX_W   = 5;
  localparam int OFF_W   = 3;
  localparam int BANK_W  = IDX_W - OFF_W;
  localparam int LEN_LSB = 16;
  localparam int LEN_W   = 3;
  localparam int STR_LSB = 20;
  localparam int STR_W   = 2;

  typedef struct packed {
    logic load;
    logic step;
  } seqStrobes_t;
endpackage

// File: rtl/svec_cfg_reg.sv
module svec_cfg_reg
  import svec_pkg::*;
#(
  parameter int CFG_W  = 32,
  parameter int RD_LAT = 2,
  parameter int WR_LAT = 4
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             wrEn,
  input  logic [CFG_W-1:0] wrData,
  input  logic             rdEn,
  output logic             rdValid,
  output logic [CFG_W-1:0] rdData,
  output logic [LEN_W-1:0] lenCode,
  output logic [STR_W-1:0] strideCode
);
  localparam int WR_STAGES = WR_LAT - 1;

  logic [CFG_W-1:0]     cfgQ;
  logic [WR_STAGES-1:0] wrV;
  logic [CFG_W-1:0]     wrD [WR_STAGES];
  logic [RD_LAT-1:0]    rdV;
  logic [CFG_W-1:0]     rdD [RD_LAT];

  // write path: the word lands WR_LAT edges after the request
  always_ff @(posedge clk) begin
    if (!rstN) begin
      cfgQ <= '0;
      for (int i = 0; i < WR_STAGES; i++) begin
        wrV[i] <= 1'b0;
        wrD[i] <= '0;
      end
    end else begin
      wrV[0] <= wrEn;
      wrD[0] <= wrData;
      for (int i = 1; i < WR_STAGES; i++) begin
        wrV[i] <= wrV[i-1];
        wrD[i] <= wrD[i-1];
      end
      if (wrV[WR_STAGES-1]) cfgQ <= wrD[WR_STAGES-1];
    end
  end

  // read path: snapshot taken at the request edge
  always_ff @(posedge clk) begin
    if (!rstN) begin
      for (int i = 0; i < RD_LAT; i++) begin
        rdV[i] <= 1'b0;
        rdD[i] <= '0;
      end
    end else begin
      rdV[0] <= rdEn;
      rdD[0] <= cfgQ;
      for (int i = 1; i < RD_LAT; i++) begin
        rdV[i] <= rdV[i-1];
        rdD[i] <= rdD[i-1];
      end
    end
  end

  assign rdValid    = rdV[RD_LAT-1];
  assign rdData     = rdD[RD_LAT-1];
  assign lenCode    = cfgQ[LEN_LSB +: LEN_W];
  assign strideCode = cfgQ[STR_LSB +: STR_W];

  assert_wr_latency_R8: assert property (@(posedge clk) disable iff (!rstN)
    (cfgQ != $past(cfgQ)) |-> $past(wrEn, WR_LAT));

  assert_rd_latency_R9: assert property (@(posedge clk) disable iff (!rstN)
    rdValid |-> ($past(rdEn, RD_LAT) && rdData == $past(cfgQ, RD_LAT)));
endmodule

// File: rtl/svec_ctrl.sv
module svec_ctrl
  import svec_pkg::*;
(
  input  logic             clk,
  input  logic             rstN,
  input  logic             issueValid,
  input  logic             dstScalar,
  input  logic [LEN_W-1:0] lenCode,
  output seqStrobes_t      strobes,
  output logic             busy,
  output logic             lastElem
);
  localparam logic [LEN_W-1:0] ONE = LEN_W'(1);

  logic             busyQ;
  logic [LEN_W-1:0] remain;

  assign strobes.load = issueValid && !busyQ;
  assign strobes.step = busyQ && (remain != '0);
  assign busy         = busyQ;
  assign lastElem     = busyQ && (remain == '0);

  always_ff @(posedge clk) begin
    if (!rstN) begin
      busyQ  <= 1'b0;
      remain <= '0;
    end else if (strobes.load) begin
      busyQ  <= 1'b1;
      remain <= dstScalar ? '0 : lenCode;
    end else if (busyQ) begin
      if (remain == '0) busyQ <= 1'b0;
      else              remain <= remain - ONE;
    end
  end

  assert_countdown_R2: assert property (@(posedge clk) disable iff (!rstN)
    (busyQ && remain != '0) |=> (busyQ && remain == $past(remain) - ONE));

  assert_scalar_single_R5: assert property (@(posedge clk) disable iff (!rstN)
    (issueValid && !busyQ && dstScalar) |=> (busyQ && lastElem));

  assert_finish_R2: assert property (@(posedge clk) disable iff (!rstN)
    lastElem |=> !busyQ);
endmodule

// File: rtl/svec_datapath.sv
module svec_datapath
  import svec_pkg::*;
(
  input  logic             clk,
  input  logic             rstN,
  input  seqStrobes_t      strobes,
  input  logic [STR_W-1:0] strideCode,
  input  logic [IDX_W-1:0] dstIdx,
  input  logic [IDX_W-1:0] srcAIdx,
  input  logic [IDX_W-1:0] srcBIdx,
  output logic [IDX_W-1:0] elemDst,
  output logic [IDX_W-1:0] elemSrcA,
  output logic [IDX_W-1:0] elemSrcB
);
  logic [OFF_W-1:0] stepAmt;
  logic             bScalar;
  logic [IDX_W-1:0] curIdx [3];
  logic [IDX_W-1:0] baseIdx [3];

  assign baseIdx[0] = dstIdx;
  assign baseIdx[1] = srcAIdx;
  assign baseIdx[2] = srcBIdx;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      stepAmt <= OFF_W'(1);
      bScalar <= 1'b0;
    end else if (strobes.load) begin
      stepAmt <= (strideCode == '1) ? OFF_W'(2) : OFF_W'(1);
      bScalar <= (srcBIdx[IDX_W-1:OFF_W] == '0);
    end
  end

  // one index channel per operand; the second source may be frozen
  for (genvar g = 0; g < 3; g++) begin : gChan
    logic hold;
    assign hold = (g == 2) && bScalar;
    always_ff @(posedge clk) begin
      if (!rstN) begin
        curIdx[g] <= '0;
      end else if (strobes.load) begin
        curIdx[g] <= baseIdx[g];
      end else if (strobes.step && !hold) begin
        curIdx[g] <= {curIdx[g][IDX_W-1:OFF_W], curIdx[g][OFF_W-1:0] + stepAmt};
      end
    end
  end

  assign elemDst  = curIdx[0];
  assign elemSrcA = curIdx[1];
  assign elemSrcB = curIdx[2];

  assert_bank_fixed_R3: assert property (@(posedge clk) disable iff (!rstN)
    strobes.step |=> (elemDst[IDX_W-1:OFF_W] == $past(elemDst[IDX_W-1:OFF_W]) &&
                      elemSrcA[IDX_W-1:OFF_W] == $past(elemSrcA[IDX_W-1:OFF_W])));

  assert_stride_step_R3: assert property (@(posedge clk) disable iff (!rstN)
    strobes.step |=> ((elemDst[OFF_W-1:0] - $past(elemDst[OFF_W-1:0])) == 3'd1 ||
                      (elemDst[OFF_W-1:0] - $past(elemDst[OFF_W-1:0])) == 3'd2));

  assert_scalar_b_R4: assert property (@(posedge clk) disable iff (!rstN)
    (strobes.step && elemSrcB[IDX_W-1:OFF_W] == '0) |=> $stable(elemSrcB));

  assert_hold_idle_R7: assert property (@(posedge clk) disable iff (!rstN)
    (!strobes.load && !strobes.step) |=> ($stable(elemDst) && $stable(elemSrcA)));
endmodule

// File: rtl/svec_sequencer.sv
module svec_sequencer
  import svec_pkg::*;
#(
  parameter int CFG_W  = 32,
  parameter int RD_LAT = 2,
  parameter int WR_LAT = 4
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             issueValid,
  input  logic [4:0]       issueDst,
  input  logic [4:0]       issueSrcA,
  input  logic [4:0]       issueSrcB,
  input  logic             cfgWrEn,
  input  logic [CFG_W-1:0] cfgWrData,
  input  logic             cfgRdEn,
  output logic             cfgRdValid,
  output logic [CFG_W-1:0] cfgRdData,
  output logic             elemValid,
  output logic [4:0]       elemDst,
  output logic [4:0]       elemSrcA,
  output logic [4:0]       elemSrcB,
  output logic             elemLast,
  output logic             busy
);
  logic [LEN_W-1:0] lenCode;
  logic [STR_W-1:0] strideCode;
  seqStrobes_t      strobes;
  logic             dstScalar;

  assign dstScalar = (issueDst[IDX_W-1:OFF_W] == '0);

  svec_cfg_reg #(.CFG_W(CFG_W), .RD_LAT(RD_LAT), .WR_LAT(WR_LAT)) uCfg (
    .clk(clk), .rstN(rstN), .wrEn(cfgWrEn), .wrData(cfgWrData),
    .rdEn(cfgRdEn), .rdValid(cfgRdValid), .rdData(cfgRdData),
    .lenCode(lenCode), .strideCode(strideCode)
  );

  svec_ctrl uCtrl (
    .clk(clk), .rstN(rstN), .issueValid(issueValid), .dstScalar(dstScalar),
    .lenCode(lenCode), .strobes(strobes), .busy(busy), .lastElem(elemLast)
  );

  svec_datapath uDp (
    .clk(clk), .rstN(rstN), .strobes(strobes), .strideCode(strideCode),
    .dstIdx(issueDst), .srcAIdx(issueSrcA), .srcBIdx(issueSrcB),
    .elemDst(elemDst), .elemSrcA(elemSrcA), .elemSrcB(elemSrcB)
  );

  assign elemValid = busy;
endmodule

// File: tb/sim_svec_sequencer.sv
module sim_svec_sequencer;
  localparam int CLK_PERIOD = 10;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic issueValid = 1'b0;
  logic [4:0] issueDst = '0, issueSrcA = '0, issueSrcB = '0;
  logic cfgWrEn = 1'b0;
  logic [31:0] cfgWrData = '0;
  logic cfgRdEn = 1'b0;
  logic cfgRdValid, elemValid, elemLast, busy;
  logic [31:0] cfgRdData;
  logic [4:0] elemDst, elemSrcA, elemSrcB;

  always #(CLK_PERIOD/2) clk = ~clk;

  svec_sequencer u0 (
    .clk(clk), .rstN(rstN), .issueValid(issueValid), .issueDst(issueDst),
    .issueSrcA(issueSrcA), .issueSrcB(issueSrcB), .cfgWrEn(cfgWrEn),
    .cfgWrData(cfgWrData), .cfgRdEn(cfgRdEn), .cfgRdValid(cfgRdValid),
    .cfgRdData(cfgRdData), .elemValid(elemValid), .elemDst(elemDst),
    .elemSrcA(elemSrcA), .elemSrcB(elemSrcB), .elemLast(elemLast), .busy(busy)
  );

  int nRun = 0, nFail = 0;
  string curTag = "R1";

  task automatic chk(string what, logic [31:0] act, logic [31:0] exp);
    nRun++;
    if (act !== exp) begin
      nFail++;
      $display("FAIL %s %s: actual %h expected %h", curTag, what, act, exp);
    end
  endtask

  // ---------------- behavioural reference model ----------------
  int cyc = 0;
  logic mBusy = 1'b0, mBScal = 1'b0;
  int mRem = 0, mI = 0, mStride = 1;
  logic [4:0] mD = '0, mA = '0, mB = '0;
  logic [31:0] mCfg = '0;
  logic [31:0] pData[$];
  int pDue[$];
  logic r1v = 1'b0, r2v = 1'b0;
  logic [31:0] r1d = '0, r2d = '0;

  function automatic logic [4:0] idxAt(logic [4:0] base, int k, int s);
    int off;
    off = (int'(base[2:0]) + k * s) % 8;
    return {base[4:3], 3'(off)};
  endfunction

  always @(posedge clk) begin
    if (!rstN) begin
      mBusy = 0; mRem = 0; mI = 0; mCfg = '0; r1v = 0; r2v = 0;
      r1d = '0; r2d = '0; pData.delete(); pDue.delete(); cyc = 0;
    end else begin
      logic [31:0] snap;
      snap = mCfg;
      r2v = r1v; r2d = r1d; r1v = cfgRdEn; r1d = snap;
      if (mBusy) begin
        if (mRem == 0) mBusy = 0;
        else begin mRem--; mI++; end
      end else if (issueValid) begin
        mBusy = 1; mI = 0;
        mRem = (issueDst[4:3] == 0) ? 0 : int'(snap[18:16]);
        mStride = (snap[21:20] == 2'b11) ? 2 : 1;
        mD = issueDst; mA = issueSrcA; mB = issueSrcB;
        mBScal = (issueSrcB[4:3] == 0);
      end
      while (pDue.size() > 0 && pDue[0] == cyc) begin
        mCfg = pData.pop_front();
        void'(pDue.pop_front());
      end
      if (cfgWrEn) begin pData.push_back(cfgWrData); pDue.push_back(cyc + 3); end
      cyc++;
    end
  end

  // compare on every cycle, away from the active edge
  always @(negedge clk) begin
    if (rstN) begin
      chk("busy", 32'(busy), 32'(mBusy));
      chk("elemValid", 32'(elemValid), 32'(mBusy));
      if (mBusy) begin
        chk("elemDst", 32'(elemDst), 32'(idxAt(mD, mI, mStride)));
        chk("elemSrcA", 32'(elemSrcA), 32'(idxAt(mA, mI, mStride)));
        chk("elemSrcB", 32'(elemSrcB), 32'(mBScal ? mB : idxAt(mB, mI, mStride)));
        chk("elemLast", 32'(elemLast), 32'(mRem == 0));
      end else begin
        chk("elemLast", 32'(elemLast), 32'd0);
      end
      chk("cfgRdValid", 32'(cfgRdValid), 32'(r2v));
      if (r2v) chk("cfgRdData", cfgRdData, r2d);
    end
  end

  // ---------------- stimulus ----------------
  task automatic waitIdle();
    @(negedge clk);
    while (busy) @(negedge clk);
  endtask

  task automatic issue(logic [4:0] d, logic [4:0] a, logic [4:0] b);
    issueValid = 1; issueDst = d; issueSrcA = a; issueSrcB = b;
    @(negedge clk);
    issueValid = 0;
  endtask

  task automatic cfgWrite(logic [31:0] v);
    cfgWrEn = 1; cfgWrData = v;
    @(negedge clk);
    cfgWrEn = 0;
  endtask

  task automatic cfgRead(output logic [31:0] v);
    cfgRdEn = 1;
    @(negedge clk);
    cfgRdEn = 0;
    @(negedge clk);
    v = cfgRdData;
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    nFail++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("[TB] %0d tests run, %0d failed", nRun, nFail);
    $finish;
  end

  initial begin
    logic [31:0] rv;
    repeat (3) @(negedge clk);
    rstN = 1;
    @(negedge clk);
    // R1: reset state
    curTag = "R1";
    chk("busy after reset", 32'(busy), 32'd0);
    cfgRead(rv);
    chk("cfg after reset", rv, 32'd0);
    issue(5'd20, 5'd12, 5'd28);   // default length 1
    waitIdle();

    // R2 and R4: length 8, destination 16, source 8, scalar 0
    curTag = "R2";
    cfgWrite(32'h0007_0000); repeat (4) @(negedge clk);
    curTag = "R4";
    issue(5'd16, 5'd8, 5'd0);
    waitIdle();

    // R3: wrap inside the bank with a vector second source
    curTag = "R3";
    issue(5'd21, 5'd13, 5'd29);
    waitIdle();

    // R6: stride code 11 gives 2, code 01 gives 1
    curTag = "R6";
    cfgWrite(32'h0037_0000); repeat (4) @(negedge clk);
    issue(5'd17, 5'd9, 5'd25);
    waitIdle();
    cfgWrite(32'h0013_0000); repeat (4) @(negedge clk);
    issue(5'd30, 5'd14, 5'd6);
    waitIdle();

    // R5: bank-0 destination issues one element only
    curTag = "R5";
    cfgWrite(32'h0037_0000); repeat (4) @(negedge clk);
    issue(5'd3, 5'd10, 5'd18);
    waitIdle();

    // R7: strobes held high while busy are dropped
    curTag = "R7";
    issueValid = 1; issueDst = 5'd24; issueSrcA = 5'd8; issueSrcB = 5'd16;
    @(negedge clk);
    issueDst = 5'd9; issueSrcA = 5'd1; issueSrcB = 5'd2;
    repeat (5) @(negedge clk);
    issueValid = 0;
    waitIdle();

    // R8: write latency, reads issued each cycle around the update
    curTag = "R8";
    cfgWrEn = 1; cfgWrData = 32'hA5C4_3E01;
    cfgRdEn = 1;
    @(negedge clk);
    cfgWrEn = 0;
    repeat (5) @(negedge clk);
    cfgRdEn = 0;
    repeat (3) @(negedge clk);
    issue(5'd12, 5'd20, 5'd7);
    waitIdle();

    // R9: read-modify-write keeps the unused bits
    curTag = "R9";
    cfgRead(rv);
    chk("read before rmw", rv, 32'hA5C4_3E01);
    cfgWrite((rv & ~32'h0007_0000) | 32'h0002_0000);
    repeat (4) @(negedge clk);
    cfgRead(rv);
    chk("read after rmw", rv, 32'hA5C2_3E01);

    // R10: writes landing mid-sequence and on the accepting edge
    curTag = "R10";
    cfgWrite(32'h0006_0000);
    issue(5'd8, 5'd16, 5'd24);     // accepted before the write lands
    cfgWrite(32'h0031_0000);
    waitIdle();
    cfgWrite(32'h0005_0000);
    @(negedge clk); @(negedge clk);
    issue(5'd26, 5'd18, 5'd4);     // accepted on the landing edge
    waitIdle();
    issue(5'd26, 5'd18, 5'd4);
    waitIdle();

    repeat (3) @(negedge clk);
    $display("[TB] %0d tests run, %0d failed", nRun, nFail);
    $finish;
  end
endmodule